// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This controller sits between ten interrupt request lines and a processor core. Each line stands for one vector, and several peripheral events may already be merged onto it by the source logic. Software sets an enable bit and a priority for every vector. A priority is low or high. Vectors 0 and 1 also have a select that raises them to a third, top level. Every cycle in which no request is being offered, the controller picks one winner among the enabled requests. That winner is the request at the highest level, and among requests at the same level it is the one with the lowest vector index. The controller then offers the winner's index, level and entry address to the core.

The offer is registered and stays frozen until the core acknowledges it. On acknowledge, the winner's level is pushed onto a small stack of in-service levels. From then on, only requests strictly above the top of that stack can be offered, which gives nested service. A return strobe pops the stack, and requests that were held back are then judged again against the lower level.

Top module: `vic3_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, `irq_o` is 0, `cur_level_o` is 0, and `vec_idx_o`, `vec_addr_o` and `irq_lvl_o` are 0.
- R2: An offered vector with index i carries the entry address 3 + 8*i on `vec_addr_o`. Vector 0 gives 0x0003 and vector 9 gives 0x004B.
- R3: A request whose bit in `en_i` is 0 is never offered. Once the enable bit is set, the request is offered.
- R4: The offered vector is the one at the highest level. Levels are encoded 1 = low, 2 = high, 3 = top, and `irq_lvl_o` carries the level of the offered vector.
- R5: Among pending requests at the same level, the lowest vector index is offered.
- R6: A vector below index 2 with its `prio_top_i` bit set has level 3. Otherwise a vector has level 2 if its `prio_hi_i` bit is 1, and level 1 if that bit is 0. Vectors 2 to 9 never reach level 3.
- R7: While `irq_o` is 1 and `ack_i` is 0, `irq_o`, `vec_idx_o`, `vec_addr_o` and `irq_lvl_o` do not change, even if requests drop or higher requests arrive.
- R8: An acknowledge while `irq_o` is 1 clears `irq_o` at the next edge and pushes the offered level. `cur_level_o` then shows that level.
- R9: A request is offered only if its level is strictly above `cur_level_o`. A strictly higher request is offered while lower levels are in service, so service nests.
- R10: A `reti_i` pulse pops one level off the stack, so `cur_level_o` falls to the level below it, or to 0. A pulse on an empty stack changes nothing.
- R11: A request that becomes eligible between edges shows on `irq_o` after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NVEC | Pending request per vector |
| en_i | input | NVEC | Enable per vector |
| prio_hi_i | input | NVEC | 1 = high level, 0 = low level |
| prio_top_i | input | NTOP | Raises vector 0 or 1 to the top level |
| ack_i | input | 1 | Core accepts the current offer |
| reti_i | input | 1 | Core has finished the innermost service |
| irq_o | output | 1 | An offer is valid |
| vec_idx_o | output | IDX_W | Index of the offered vector |
| vec_addr_o | output | ADDR_W | Entry address of the offered vector |
| irq_lvl_o | output | 2 | Level of the offered vector |
| cur_level_o | output | 2 | Level on top of the in-service stack, 0 when none |

## Verification
An offer appears one edge after its request becomes eligible, so the bench drives inputs just after an edge and samples one edge later. It also checks that `irq_o` is still low before that edge. An acknowledge clears `irq_o` and updates `cur_level_o` at the same edge. A return strobe lowers `cur_level_o` at its edge, but a request it releases is offered only at the following edge, so the bench checks both of those cycles separately. The stability checks hold a request over several edges without acknowledging it and confirm that the outputs do not move.

// File: rtl/vic3_pkg.sv
package vic3_pkg;
  localparam logic [1:0] LV_NONE = 2'd0;
  localparam logic [1:0] LV_LOW  = 2'd1;
  localparam logic [1:0] LV_HIGH = 2'd2;
  localparam logic [1:0] LV_TOP  = 2'd3;

  // entry address of vector idx
  function automatic int vec_offset(int idx, int base, int stride);
    return base + stride * idx;
  endfunction
endpackage

// File: rtl/vic3_level_map.sv
module vic3_level_map #(
  parameter int NVEC = 10,
  parameter int NTOP = 2
) (
  input  logic [NVEC-1:0]      req_i,
  input  logic [NVEC-1:0]      en_i,
  input  logic [NVEC-1:0]      prio_hi_i,
  input  logic [NTOP-1:0]      prio_top_i,
  output logic [NVEC-1:0][1:0] lvl_o
);
  import vic3_pkg::*;

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    logic [1:0] base_lvl;
    assign base_lvl = prio_hi_i[g] ? LV_HIGH : LV_LOW;
    if (g < NTOP) begin : g_top
      assign lvl_o[g] = (req_i[g] && en_i[g]) ?
                        (prio_top_i[g] ? LV_TOP : base_lvl) : LV_NONE;
    end else begin : g_plain
      assign lvl_o[g] = (req_i[g] && en_i[g]) ? base_lvl : LV_NONE;
    end
  end
endmodule

// File: rtl/vic3_arbiter.sv
module vic3_arbiter #(
  parameter int NVEC  = 10,
  parameter int IDX_W = $clog2(NVEC)
) (
  input  logic [NVEC-1:0][1:0] lvl_i,
  input  logic [1:0]           cur_i,
  output logic                 vld_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [1:0]           lvl_o
);
  // scan downward with >= so the lowest index wins a tie
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = 2'd0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (lvl_i[i] > cur_i && lvl_i[i] >= lvl_o) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/vic3_svc_stack.sv
module vic3_svc_stack #(
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push_i,
  input  logic [1:0] push_lvl_i,
  input  logic       pop_i,
  output logic [1:0] top_o
);
  logic [1:0]    mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [PW-1:0] top_ptr;
  logic [PW-1:0] wr_ptr;

  assign top_ptr = PW'(cnt - CW'(1));
  assign wr_ptr  = PW'(cnt);
  assign top_o   = (cnt == '0) ? 2'd0 : mem[top_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case ({push_i, pop_i})
        2'b10: if (cnt < CW'(DEPTH)) begin
          mem[wr_ptr] <= push_lvl_i;
          cnt         <= cnt + CW'(1);
        end
        2'b01: if (cnt != '0) cnt <= cnt - CW'(1);
        2'b11: if (cnt != '0) begin
          mem[top_ptr] <= push_lvl_i;
        end else begin
          mem[wr_ptr] <= push_lvl_i;
          cnt         <= CW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vic3_ctrl.sv
module vic3_ctrl #(
  parameter int NVEC   = 10,
  parameter int NTOP   = 2,
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 16,
  parameter int BASE   = 3,
  parameter int STRIDE = 8,
  localparam int IDX_W = $clog2(NVEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NVEC-1:0]   req_i,
  input  logic [NVEC-1:0]   en_i,
  input  logic [NVEC-1:0]   prio_hi_i,
  input  logic [NTOP-1:0]   prio_top_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  vec_idx_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [1:0]        irq_lvl_o,
  output logic [1:0]        cur_level_o
);
  logic [NVEC-1:0][1:0] lvl;
  logic                 win_vld;
  logic [IDX_W-1:0]     win_idx;
  logic [1:0]           win_lvl;
  logic [1:0]           top_lvl;
  logic                 push;

  vic3_level_map #(.NVEC(NVEC), .NTOP(NTOP)) u_map (
    .req_i(req_i), .en_i(en_i), .prio_hi_i(prio_hi_i),
    .prio_top_i(prio_top_i), .lvl_o(lvl)
  );

  vic3_arbiter #(.NVEC(NVEC), .IDX_W(IDX_W)) u_arb (
    .lvl_i(lvl), .cur_i(top_lvl),
    .vld_o(win_vld), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign push = irq_o && ack_i;

  vic3_svc_stack #(.DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push_i(push), .push_lvl_i(irq_lvl_o),
    .pop_i(reti_i), .top_o(top_lvl)
  );

  assign cur_level_o = top_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      vec_idx_o  <= '0;
      vec_addr_o <= '0;
      irq_lvl_o  <= 2'd0;
    end else if (irq_o) begin
      if (ack_i) irq_o <= 1'b0;
    end else if (win_vld) begin
      irq_o      <= 1'b1;
      vec_idx_o  <= win_idx;
      irq_lvl_o  <= win_lvl;
      vec_addr_o <= ADDR_W'(vic3_pkg::vec_offset(int'(win_idx), BASE, STRIDE));
    end
  end
endmodule

// File: rtl/vic3_ctrl_chk.sv
module vic3_ctrl_chk #(
  parameter int NTOP   = 2,
  parameter int ADDR_W = 16,
  parameter int BASE   = 3,
  parameter int STRIDE = 8,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ack_i,
  input logic              reti_i,
  input logic              irq_o,
  input logic [IDX_W-1:0]  vec_idx_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [1:0]        irq_lvl_o,
  input logic [1:0]        cur_level_o
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!irq_o && cur_level_o == 2'd0)); // R1

  AST_ADDR_MAP: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (32'(vec_addr_o) == 32'(BASE) + 32'(STRIDE) * 32'(vec_idx_o))); // R2

  AST_TOP_ONLY_LOW_VEC: assert property (@(posedge clk) disable iff (rst)
    (irq_o && irq_lvl_o == 2'd3) |-> (32'(vec_idx_o) < NTOP)); // R6

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_idx_o) && $stable(irq_lvl_o))); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i) |=> !irq_o); // R8

  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i && !reti_i) |=> (cur_level_o == $past(irq_lvl_o))); // R8

  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (irq_lvl_o > cur_level_o)); // R9
endmodule

bind vic3_ctrl vic3_ctrl_chk #(
  .NTOP(NTOP), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o),
  .vec_idx_o(vec_idx_o), .vec_addr_o(vec_addr_o), .irq_lvl_o(irq_lvl_o),
  .cur_level_o(cur_level_o)
);

// File: tb/tb_vic3_ctrl.sv
`timescale 1ns/1ps
module tb_vic3_ctrl;
  localparam int NVEC = 10;
  localparam int NTOP = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NVEC-1:0] req = '0, en = '0, phi = '0;
  logic [NTOP-1:0] ptop = '0;
  logic            ack = 1'b0, reti = 1'b0;
  logic            irq;
  logic [3:0]      idx;
  logic [15:0]     addr;
  logic [1:0]      ilvl, cur;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vic3_ctrl dut (
    .clk(clk), .rst(rst), .req_i(req), .en_i(en), .prio_hi_i(phi),
    .prio_top_i(ptop), .ack_i(ack), .reti_i(reti), .irq_o(irq),
    .vec_idx_o(idx), .vec_addr_o(addr), .irq_lvl_o(ilvl), .cur_level_o(cur)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // accept the current offer, then return from it
  task automatic take_and_return();
    ack = 1'b1; req = '0; tick(); ack = 1'b0;
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  task automatic t_reset();
    tick(); tick();
    chk("R1", "irq in reset", irq, 0);
    chk("R1", "cur in reset", cur, 0);
    chk("R1", "addr in reset", addr, 0);
    chk("R1", "lvl in reset", ilvl, 0);
    rst = 1'b0; tick();
    chk("R1", "irq after reset", irq, 0);
  endtask

  task automatic t_addr_map();
    en = '1; phi = '0; ptop = '0;
    for (int i = 0; i < NVEC; i++) begin
      req = NVEC'(1) << i;
      if (i == 0) chk("R11", "irq before edge", irq, 0);
      tick();
      chk("R11", "irq one edge later", irq, 1);
      chk("R2", "index", idx, i);
      chk("R2", "address", addr, 3 + 8 * i);
      ack = 1'b1; req = '0; tick(); ack = 1'b0;
      chk("R8", "irq after ack", irq, 0);
      chk("R8", "cur after ack", cur, 1);
      reti = 1'b1; tick(); reti = 1'b0;
      chk("R10", "cur after reti", cur, 0);
    end
  endtask

  task automatic t_enable();
    en = ~(NVEC'(1) << 2); phi = '0; req = NVEC'(1) << 2;
    tick(); tick(); tick();
    chk("R3", "disabled request offered", irq, 0);
    en = '1; tick();
    chk("R3", "irq once enabled", irq, 1);
    chk("R3", "index once enabled", idx, 2);
    take_and_return();
  endtask

  task automatic t_priority();
    en = '1; phi = NVEC'(1) << 7; ptop = '0;
    req = (NVEC'(1) << 7) | NVEC'(2); tick();
    chk("R4", "high over low index", idx, 7);
    chk("R4", "high level", ilvl, 2);
    take_and_return();
    ptop = 2'b01; phi = NVEC'(1) << 9;
    req = NVEC'(1) | (NVEC'(1) << 9); tick();
    chk("R4", "top over high index", idx, 0);
    chk("R4", "top level", ilvl, 3);
    take_and_return();
    ptop = '0;
  endtask

  task automatic t_tie();
    en = '1; ptop = '0; phi = (NVEC'(1) << 3) | (NVEC'(1) << 6);
    req = (NVEC'(1) << 3) | (NVEC'(1) << 6) | NVEC'(1); tick();
    chk("R5", "high tie index", idx, 3);
    take_and_return();
    phi = '0; req = (NVEC'(1) << 5) | (NVEC'(1) << 8); tick();
    chk("R5", "low tie index", idx, 5);
    take_and_return();
  endtask

  task automatic t_top();
    en = '1; ptop = 2'b10; phi = NVEC'(1);
    req = NVEC'(3); tick();
    chk("R6", "top vector 1 beats high vector 0", idx, 1);
    chk("R6", "vector 1 level", ilvl, 3);
    take_and_return();
    ptop = 2'b11; phi = '1; req = NVEC'(1) << 9; tick();
    chk("R6", "vector 9 capped at high", ilvl, 2);
    take_and_return();
    ptop = '0; phi = '0;
  endtask

  task automatic t_hold();
    en = '1; phi = '0; ptop = 2'b01;
    req = NVEC'(1) << 6; tick();
    chk("R7", "offer index", idx, 6);
    req = NVEC'(1); tick(); tick();
    chk("R7", "irq held", irq, 1);
    chk("R7", "index held", idx, 6);
    chk("R7", "address held", addr, 51);
    chk("R7", "level held", ilvl, 1);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R8", "irq dropped", irq, 0);
    tick();
    chk("R9", "nested top offer", irq, 1);
    chk("R9", "nested index", idx, 0);
    ack = 1'b1; req = '0; tick(); ack = 1'b0;
    chk("R8", "cur nested", cur, 3);
    reti = 1'b1; tick();
    chk("R10", "cur after first pop", cur, 1);
    tick();
    chk("R10", "cur after second pop", cur, 0);
    tick(); reti = 1'b0;
    chk("R10", "pop on empty", cur, 0);
    chk("R10", "no offer after empty pop", irq, 0);
    ptop = '0;
  endtask

  task automatic t_block();
    en = '1; ptop = '0; phi = NVEC'(1) << 2;
    req = NVEC'(1) << 8; tick();
    ack = 1'b1; req = '0; tick(); ack = 1'b0;
    chk("R8", "cur low", cur, 1);
    req = (NVEC'(1) << 9) | (NVEC'(1) << 2); tick();
    chk("R9", "higher nested index", idx, 2);
    ack = 1'b1; req = NVEC'(1) << 9; tick(); ack = 1'b0;
    chk("R8", "cur high", cur, 2);
    tick();
    chk("R9", "low blocked under high", irq, 0);
    reti = 1'b1; tick(); reti = 1'b0;
    chk("R10", "cur back to low", cur, 1);
    tick(); tick();
    chk("R9", "equal level blocked", irq, 0);
    reti = 1'b1; tick(); reti = 1'b0;
    chk("R10", "cur back to none", cur, 0);
    chk("R10", "irq not yet after pop", irq, 0);
    tick();
    chk("R10", "released request offered", irq, 1);
    chk("R10", "released index", idx, 9);
    take_and_return();
  endtask

  initial begin
    t_reset();
    t_addr_map();
    t_enable();
    t_priority();
    t_tie();
    t_top();
    t_hold();
    t_block();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule